// File: doc/BRIEF.md
# Crystal Frequency Auto-Detector

This block works out the frequency of an external crystal clock of unknown value by timing it against a trusted on-chip reference clock. The reference runs at a nominal 16 MHz with 1% tolerance. The crystal clock is first divided by 31 in its own domain. The divided signal is then brought into the reference domain, and the reference cycles spanned by several of its periods are counted. From that count the block computes the crystal frequency, rounded to whole MHz. It then proposes a pre-PLL divider equal to that number, so that the PLL sees a 1 MHz input.

Boot logic pulses `start` and waits for `done`. While a measurement runs, and whenever no trusted result exists, the divider output stays at 25. This is the safe value for the largest supported crystal, so the core cannot be overclocked by mistake. A crystal that never starts ends the measurement with `timeout` rather than a hang.

Top module: `xtal_freq_detect`

## Requirements
- R1: After reset, busy, done, valid and timeout are 0, freq_mhz is 0 and pll_div is 25.
- R2: A start pulse while idle sets busy on the next clock edge. While busy, pll_div is 25 and valid is 0.
- R3: The crystal clock is divided by 31. The first divided rising edge after start only arms the count. The reference cycles spanned by the next 8 divided periods form a total T. freq_mhz is floor((16·31·8 + floor(T/2)) / T), which is the nearest integer MHz, saturated to the port width.
- R4: done is a one-cycle pulse, raised in the same cycle that busy falls. valid, timeout, freq_mhz and pll_div then hold until the next accepted start.
- R5: A result is valid when freq_mhz lies in 4..24 and the implied PLL input passes the check of R7. When valid, pll_div equals freq_mhz.
- R6: A rounded frequency below 4 or above 24 (for example, a 2 MHz or 25 MHz crystal) gives valid 0 and pll_div 25. freq_mhz still shows the rounded value.
- R7: The implied PLL input is the measured frequency divided by freq_mhz. If it falls outside 0.95..2.1 MHz, the result is invalid. For example, a 3.6 MHz crystal rounds to 4 but is rejected.
- R8: If no divided edge arrives within 1024 reference cycles while arming or counting, the run ends with timeout 1, valid 0, freq_mhz 0 and pll_div 25.
- R9: A start pulse while busy is ignored. The running measurement finishes once, with the result it would have had anyway.
- R10: valid and timeout are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 16 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a measurement |
| xtal_clk | input | 1 | Raw crystal clock of unknown frequency |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Result usable for PLL setup |
| timeout | output | 1 | No crystal edges were seen |
| freq_mhz | output | 6 | Rounded crystal frequency in MHz |
| pll_div | output | 6 | Proposed pre-PLL divider (25 unless valid) |

## Verification
The assertions assume that start is a clean synchronous pulse in the reference domain and that reset is held for at least one edge. They also assume the crystal is either steady in frequency for the whole of a run or fully stopped. The stimulus changes crystal frequency only while the block is idle. After each change it waits several hundred reference cycles, so the divider and synchronizer carry no edge left over from an earlier setting. Start is always driven away from the clock edge for exactly one cycle.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  typedef enum logic [1:0] {
    M_IDLE,
    M_ARM,
    M_RUN
  } meter_st_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_DIV,
    C_FIN
  } calc_st_t;
endpackage

// File: rtl/xfd_prescaler.sv
module xfd_prescaler #(
  parameter int unsigned DIV = 31
) (
  input  logic xtal_clk,
  output logic div_out
);
  localparam int unsigned W = $clog2(DIV);

  // Free-running in the crystal domain; power-up values stand in for a reset
  // because the crystal may never toggle.
  logic [W-1:0] cnt = '0;
  logic         q   = 1'b0;

  always_ff @(posedge xtal_clk) begin
    if (cnt == W'(DIV - 1)) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
    q <= (cnt < W'(DIV / 2));
  end

  assign div_out = q;
endmodule

// File: rtl/xfd_edge_sync.sv
module xfd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      rise <= 1'b0;
    end else begin
      s1   <= async_in;
      s2   <= s1;
      s3   <= s2;
      rise <= s2 & ~s3;
    end
  end
endmodule

// File: rtl/xfd_period_meter.sv
module xfd_period_meter
  import xfd_pkg::*;
#(
  parameter int unsigned PERIODS     = 8,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned CW          = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          edge_in,
  output logic          done,
  output logic          timed_out,
  output logic [CW-1:0] total
);
  localparam int unsigned GW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned PW = $clog2(PERIODS + 1);

  meter_st_t     st;
  logic [GW-1:0] gap;
  logic [PW-1:0] per;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= M_IDLE;
      gap       <= '0;
      per       <= '0;
      total     <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        M_IDLE: begin
          if (start) begin
            st        <= M_ARM;
            gap       <= '0;
            per       <= '0;
            total     <= '0;
            timed_out <= 1'b0;
          end
        end
        M_ARM: begin
          if (edge_in) begin
            st  <= M_RUN;
            gap <= '0;
          end else if (gap == GW'(TIMEOUT_CYC - 1)) begin
            st        <= M_IDLE;
            timed_out <= 1'b1;
            done      <= 1'b1;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        M_RUN: begin
          total <= total + 1'b1;
          if (edge_in) begin
            gap <= '0;
            per <= per + 1'b1;
            if (per == PW'(PERIODS - 1)) begin
              st   <= M_IDLE;
              done <= 1'b1;
            end
          end else if (gap == GW'(TIMEOUT_CYC - 1)) begin
            st        <= M_IDLE;
            timed_out <= 1'b1;
            done      <= 1'b1;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfd_classifier.sv
module xfd_classifier
  import xfd_pkg::*;
#(
  parameter int unsigned NUM     = 3968,
  parameter int unsigned CW      = 14,
  parameter int unsigned DW      = 14,
  parameter int unsigned OUT_W   = 6,
  parameter int unsigned MIN_MHZ = 4,
  parameter int unsigned MAX_MHZ = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CW-1:0]    total,
  output logic             done,
  output logic             ok,
  output logic [OUT_W-1:0] mhz
);
  localparam int unsigned SW = $clog2(DW + 1);
  localparam int unsigned XW = DW + DW + 6;

  calc_st_t      st;
  logic [DW-1:0] dvd;
  logic [DW-1:0] den;
  logic [DW-1:0] rem;
  logic [SW-1:0] step;

  logic [DW:0]   rem_sh;
  logic          take;
  logic [DW:0]   diff;
  logic          in_band;
  logic [XW-1:0] prod;
  logic          lo_ok, hi_ok;
  logic [OUT_W-1:0] sat;

  always_comb begin
    rem_sh  = {rem, dvd[DW-1]};
    take    = (rem_sh >= {1'b0, den});
    diff    = rem_sh - {1'b0, den};
    in_band = (dvd >= DW'(MIN_MHZ)) && (dvd <= DW'(MAX_MHZ));
    prod    = XW'(den) * XW'(dvd);
    // PLL input = measured / rounded; keep 0.95 <= ratio <= 2.1
    lo_ok   = (XW'(NUM) * XW'(20)) >= (XW'(19) * prod);
    hi_ok   = (XW'(NUM) * XW'(10)) <= (XW'(21) * prod);
    sat     = (dvd > DW'((1 << OUT_W) - 1)) ? '1 : dvd[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= C_IDLE;
      dvd  <= '0;
      den  <= '0;
      rem  <= '0;
      step <= '0;
      done <= 1'b0;
      ok   <= 1'b0;
      mhz  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        C_IDLE: begin
          if (go) begin
            dvd  <= DW'(NUM) + DW'(total >> 1);
            den  <= DW'(total);
            rem  <= '0;
            step <= SW'(DW);
            st   <= C_DIV;
          end
        end
        C_DIV: begin
          rem  <= take ? diff[DW-1:0] : rem_sh[DW-1:0];
          dvd  <= {dvd[DW-2:0], take};
          step <= step - 1'b1;
          if (step == SW'(1)) st <= C_FIN;
        end
        C_FIN: begin
          mhz  <= sat;
          ok   <= in_band && lo_ok && hi_ok;
          done <= 1'b1;
          st   <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xtal_freq_detect.sv
module xtal_freq_detect #(
  parameter int unsigned REF_MHZ     = 16,
  parameter int unsigned PRESCALE    = 31,
  parameter int unsigned PERIODS     = 8,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned MIN_MHZ     = 4,
  parameter int unsigned MAX_MHZ     = 24,
  parameter int unsigned DEF_DIV     = 25,
  parameter int unsigned OUT_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             xtal_clk,
  output logic             busy,
  output logic             done,
  output logic             valid,
  output logic             timeout,
  output logic [OUT_W-1:0] freq_mhz,
  output logic [OUT_W-1:0] pll_div
);
  localparam int unsigned NUM = REF_MHZ * PRESCALE * PERIODS;
  localparam int unsigned CW  = $clog2(PERIODS * TIMEOUT_CYC + 1);
  localparam int unsigned DW  = $clog2(NUM + PERIODS * TIMEOUT_CYC + 1);

  logic          div_sig;
  logic          edge_ref;
  logic          meas_done, meas_to;
  logic [CW-1:0] meas_total;
  logic          calc_done, calc_ok;
  logic [OUT_W-1:0] calc_mhz;
  logic          start_acc;

  assign start_acc = start & ~busy;

  xfd_prescaler #(.DIV(PRESCALE)) u_pre (
    .xtal_clk (xtal_clk),
    .div_out  (div_sig)
  );

  xfd_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (div_sig),
    .rise     (edge_ref)
  );

  xfd_period_meter #(
    .PERIODS     (PERIODS),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CW          (CW)
  ) u_meter (
    .clk       (clk),
    .rst       (rst),
    .start     (start_acc),
    .edge_in   (edge_ref),
    .done      (meas_done),
    .timed_out (meas_to),
    .total     (meas_total)
  );

  xfd_classifier #(
    .NUM     (NUM),
    .CW      (CW),
    .DW      (DW),
    .OUT_W   (OUT_W),
    .MIN_MHZ (MIN_MHZ),
    .MAX_MHZ (MAX_MHZ)
  ) u_calc (
    .clk   (clk),
    .rst   (rst),
    .go    (meas_done & ~meas_to),
    .total (meas_total),
    .done  (calc_done),
    .ok    (calc_ok),
    .mhz   (calc_mhz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      valid    <= 1'b0;
      timeout  <= 1'b0;
      freq_mhz <= '0;
      pll_div  <= OUT_W'(DEF_DIV);
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        busy     <= 1'b1;
        valid    <= 1'b0;
        timeout  <= 1'b0;
        freq_mhz <= '0;
        pll_div  <= OUT_W'(DEF_DIV);
      end else if (meas_done && meas_to) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        timeout <= 1'b1;
      end else if (calc_done) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        valid    <= calc_ok;
        freq_mhz <= calc_mhz;
        pll_div  <= calc_ok ? calc_mhz : OUT_W'(DEF_DIV);
      end
    end
  end
endmodule

// File: rtl/xfd_checker.sv
module xfd_checker #(
  parameter int unsigned MIN_MHZ = 4,
  parameter int unsigned MAX_MHZ = 24,
  parameter int unsigned DEF_DIV = 25,
  parameter int unsigned OUT_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             valid,
  input logic             timeout,
  input logic [OUT_W-1:0] freq_mhz,
  input logic [OUT_W-1:0] pll_div
);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_safe_div_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pll_div == OUT_W'(DEF_DIV)) && !valid);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_hold_result_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable({valid, timeout, freq_mhz, pll_div}));

  assert_valid_band_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> (pll_div == freq_mhz) && (freq_mhz >= OUT_W'(MIN_MHZ))
              && (freq_mhz <= OUT_W'(MAX_MHZ)));

  assert_invalid_default_R6: assert property (@(posedge clk) disable iff (rst)
    !valid |-> pll_div == OUT_W'(DEF_DIV));

  assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (freq_mhz == '0) && (pll_div == OUT_W'(DEF_DIV)));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(valid && timeout));
endmodule

bind xtal_freq_detect xfd_checker #(
  .MIN_MHZ (MIN_MHZ),
  .MAX_MHZ (MAX_MHZ),
  .DEF_DIV (DEF_DIV),
  .OUT_W   (OUT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .valid    (valid),
  .timeout  (timeout),
  .freq_mhz (freq_mhz),
  .pll_div  (pll_div)
);

// File: tb/xtal_freq_detect_bench.sv
`timescale 1ns/1ps
module xtal_freq_detect_bench;
  localparam real CLK_PERIOD = 62.5;
  localparam int  OUT_W      = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic xtal = 1'b0;
  logic busy, done, valid, timeout;
  logic [OUT_W-1:0] freq_mhz, pll_div;

  real half_ns = 62.5;
  bit  xt_on   = 1'b0;
  int  nchk = 0;
  int  nerr = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  always begin
    if (xt_on) begin
      #(half_ns) xtal = ~xtal;
    end else begin
      #(10.0);
    end
  end

  xtal_freq_detect u_xtal_freq_detect (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .xtal_clk (xtal),
    .busy     (busy),
    .done     (done),
    .valid    (valid),
    .timeout  (timeout),
    .freq_mhz (freq_mhz),
    .pll_div  (pll_div)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (!seen) chk("watchdog R4 done never came", 0, 1);
  endtask

  task automatic test_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 timeout", int'(timeout), 0);
    chk("R1 freq", int'(freq_mhz), 0);
    chk("R1 pll_div", int'(pll_div), 25);
  endtask

  task automatic test_crystal(input real f_mhz);
    int  exp_f;
    bit  exp_ok;
    real ratio;
    bit  seen;
    half_ns = 500.0 / f_mhz;
    xt_on   = 1'b1;
    idle(300);
    pulse_start();
    chk("R2 busy after start", int'(busy), 1);
    chk("R2 safe divider while busy", int'(pll_div), 25);
    chk("R2 valid low while busy", int'(valid), 0);
    wait_done(seen);
    exp_f  = $rtoi(f_mhz + 0.5);
    ratio  = f_mhz / real'(exp_f);
    exp_ok = (exp_f >= 4) && (exp_f <= 24) && (ratio >= 0.95) && (ratio <= 2.1);
    chk($sformatf("R3 freq for %0.2f MHz", f_mhz), int'(freq_mhz), exp_f);
    if (exp_f < 4 || exp_f > 24)
      chk($sformatf("R6 valid out of band %0.2f MHz", f_mhz), int'(valid), 0);
    else if (!exp_ok)
      chk($sformatf("R7 pll input range %0.2f MHz", f_mhz), int'(valid), 0);
    else
      chk($sformatf("R5 valid %0.2f MHz", f_mhz), int'(valid), 1);
    chk("R5 pll_div", int'(pll_div), exp_ok ? exp_f : 25);
    chk("R10 timeout low", int'(timeout), 0);
    chk("R4 busy falls with done", int'(busy), 0);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
    chk("R4 freq held", int'(freq_mhz), exp_f);
  endtask

  task automatic test_busy_start();
    bit seen;
    int dones;
    half_ns = 62.5;
    xt_on   = 1'b1;
    idle(300);
    pulse_start();
    idle(100);
    pulse_start();
    chk("R9 still busy after extra start", int'(busy), 1);
    wait_done(seen);
    chk("R9 result unchanged", int'(freq_mhz), 8);
    chk("R9 valid", int'(valid), 1);
    dones = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (done || busy) dones++;
    end
    chk("R9 no second run", dones, 0);
  endtask

  task automatic test_timeout();
    bit seen;
    xt_on = 1'b0;
    idle(300);
    pulse_start();
    wait_done(seen);
    chk("R8 timeout set", int'(timeout), 1);
    chk("R8 valid low", int'(valid), 0);
    chk("R8 freq zero", int'(freq_mhz), 0);
    chk("R8 pll_div safe", int'(pll_div), 25);
    chk("R10 not both", int'(valid & timeout), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_crystal(8.0);
    test_crystal(4.0);
    test_crystal(24.0);
    test_crystal(12.0);
    test_crystal(16.0);
    test_crystal(2.0);
    test_crystal(25.0);
    test_crystal(3.6);
    test_busy_start();
    test_timeout();
    test_crystal(8.0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000.0);
    nchk++;
    nerr++;
    $display("FAIL watchdog R4 run did not finish actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule